// File: doc/BRIEF.md
# Sum-of-Products Logic Array Core

This block is the combinational heart of a small programmable logic device. Twenty input signals are each presented to the array in true and inverted form, which gives forty columns. Sixty-four product-term rows each AND together whichever columns their stored connection map selects. The rows fall into eight fixed, non-overlapping groups of eight, and each group is ORed into one output sum. A group can instead give its first term to an output-enable signal and sum only the other seven.

The connection map is held in on-chip registers. It is written one row per clock through an address/data port with a write strobe, and it can be read back on the same port. A sticky protection flag hides the stored map from readback. Only a full erase clears that flag, and the erase also blanks every row. The product terms, the sums and the enables are purely combinational from the signal inputs and the stored map.

Top module: `sop_array_core`

## Requirements
- R1: Product term r is the AND of every column whose map bit is 1 in row r. Column 2i carries signal i true and column 2i+1 carries signal i inverted, and term r appears on term_out bit r.
- R2: A row with no map bits set drives its product term HIGH for every input pattern.
- R3: A row that connects both column 2i and column 2i+1 drives its product term LOW for every input pattern.
- R4: When oe_mode bit g is 0, sum_out bit g is the OR of terms 8g to 8g+7 and oe_out bit g is 1.
- R5: When oe_mode bit g is 1, oe_out bit g equals term 8g and sum_out bit g is the OR of terms 8g+1 to 8g+7.
- R6: A cfg_we pulse at a rising edge stores cfg_wdata in row cfg_addr. The new row takes effect on the terms and on readback after that edge.
- R7: While the protection flag is clear, cfg_rdata shows the stored row selected by cfg_addr, with no register delay.
- R8: A cfg_lock pulse at a rising edge sets the protection flag. From then on cfg_rdata is zero, while writes still change the terms.
- R9: A cfg_erase pulse at a rising edge clears every row and the protection flag. Erase takes priority over a write or a lock in the same cycle, and nothing else clears the flag.
- R10: While rst_n is low, every row and the protection flag are cleared, so all terms and sums are HIGH and cfg_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 20 | Array input signals |
| oe_mode | input | 8 | Per-output selection of product-term enable |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 6 | Row address for write and readback |
| cfg_wdata | input | 40 | Row data to be written |
| cfg_lock | input | 1 | Sets the protection flag |
| cfg_erase | input | 1 | Clears all rows and the protection flag |
| cfg_rdata | output | 40 | Readback of the addressed row, or zero when protected |
| term_out | output | 64 | All product terms |
| sum_out | output | 8 | Per-output OR sums |
| oe_out | output | 8 | Per-output enable |

## Verification
Terms, sums, enables and readback are combinational, so the bench checks them 1 ns after it changes sig_in, oe_mode or cfg_addr, all within the same cycle. Writes, locks and erases are driven at a falling edge and take hold at the next rising edge, so their results are sampled at the falling edge that follows that rising edge, one cycle after the strobe. Random maps are compared against a bench model for every term, sum and enable, under a table of input patterns and two enable settings.

// File: rtl/sop_pkg.sv
package sop_pkg;
  parameter int N_SIG_DEF   = 20;
  parameter int N_ROWS_DEF  = 64;
  parameter int GROUP_DEF   = 8;
endpackage

// File: rtl/sop_fuse_store.sv
module sop_fuse_store #(
  parameter int N_COL  = 40,
  parameter int N_ROWS = 64,
  parameter int AW     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  addr,
  input  logic [N_COL-1:0]               wdata,
  input  logic                           lock_set,
  input  logic                           erase,
  output logic [N_COL-1:0]               rdata,
  output logic [N_ROWS-1:0][N_COL-1:0]   map
);
  logic [N_ROWS-1:0][N_COL-1:0] map_q, map_d;
  logic                         map_en;
  logic                         lock_q, lock_d;

  // Next-state logic: erase wins over write and over lock
  always_comb begin
    map_d  = map_q;
    map_en = erase | we;
    if (erase) map_d = '0;
    else if (we) map_d[addr] = wdata;
    lock_d = erase ? 1'b0 : (lock_q | lock_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (map_en) map_q <= map_d;
      lock_q <= lock_d;
    end
  end

  assign map   = map_q;
  assign rdata = lock_q ? '0 : map_q[addr];
endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
  parameter int N_SIG  = 20,
  parameter int N_ROWS = 64,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]              sig,
  input  logic [N_ROWS-1:0][N_COL-1:0]  map,
  output logic [N_ROWS-1:0]             term
);
  logic [N_COL-1:0] cols;

  for (genvar i = 0; i < N_SIG; i++) begin : g_col
    assign cols[2*i]   = sig[i];
    assign cols[2*i+1] = ~sig[i];
  end

  // An unconnected column contributes a 1; a clash of true and inverted gives 0
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign term[r] = &(cols | ~map[r]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_ROWS = 64,
  parameter int GROUP  = 8,
  localparam int N_OUT = N_ROWS / GROUP
) (
  input  logic [N_ROWS-1:0] term,
  input  logic [N_OUT-1:0]  oe_mode,
  output logic [N_OUT-1:0]  sum,
  output logic [N_OUT-1:0]  oe
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [GROUP-1:0] slice;
    assign slice  = term[g*GROUP +: GROUP];
    assign sum[g] = oe_mode[g] ? |slice[GROUP-1:1] : |slice;
    assign oe[g]  = oe_mode[g] ? slice[0] : 1'b1;
  end
endmodule

// File: rtl/sop_array_core.sv
module sop_array_core #(
  parameter int N_SIG  = sop_pkg::N_SIG_DEF,
  parameter int N_ROWS = sop_pkg::N_ROWS_DEF,
  parameter int GROUP  = sop_pkg::GROUP_DEF,
  localparam int N_COL = 2 * N_SIG,
  localparam int N_OUT = N_ROWS / GROUP,
  localparam int AW    = $clog2(N_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] sig_in,
  input  logic [N_OUT-1:0] oe_mode,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [N_COL-1:0] cfg_wdata,
  input  logic             cfg_lock,
  input  logic             cfg_erase,
  output logic [N_COL-1:0] cfg_rdata,
  output logic [N_ROWS-1:0] term_out,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_out
);
  logic [N_ROWS-1:0][N_COL-1:0] map;

  sop_fuse_store #(.N_COL(N_COL), .N_ROWS(N_ROWS), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .lock_set (cfg_lock),
    .erase    (cfg_erase),
    .rdata    (cfg_rdata),
    .map      (map)
  );

  sop_term_plane #(.N_SIG(N_SIG), .N_ROWS(N_ROWS)) u_terms (
    .sig  (sig_in),
    .map  (map),
    .term (term_out)
  );

  sop_or_plane #(.N_ROWS(N_ROWS), .GROUP(GROUP)) u_sums (
    .term    (term_out),
    .oe_mode (oe_mode),
    .sum     (sum_out),
    .oe      (oe_out)
  );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_SIG  = sop_pkg::N_SIG_DEF,
  parameter int N_ROWS = sop_pkg::N_ROWS_DEF,
  parameter int GROUP  = sop_pkg::GROUP_DEF,
  localparam int N_COL = 2 * N_SIG,
  localparam int N_OUT = N_ROWS / GROUP,
  localparam int AW    = $clog2(N_ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_OUT-1:0]  oe_mode,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [N_COL-1:0]  cfg_wdata,
  input logic              cfg_lock,
  input logic              cfg_erase,
  input logic [N_COL-1:0]  cfg_rdata,
  input logic [N_ROWS-1:0] term_out,
  input logic [N_OUT-1:0]  sum_out,
  input logic [N_OUT-1:0]  oe_out
);
  logic             lock_seen_q;
  logic [N_OUT-1:0] first_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_seen_q <= 1'b0;
    else if (cfg_erase) lock_seen_q <= 1'b0;
    else if (cfg_lock) lock_seen_q <= 1'b1;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_first
    assign first_term[g] = term_out[g*GROUP];
  end

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_erase && !cfg_lock && !lock_seen_q) ##1 $stable(cfg_addr)
      |-> cfg_rdata == $past(cfg_wdata)); // R6

  AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen_q |-> cfg_rdata == '0); // R8

  AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (&term_out) && (&sum_out) && (cfg_rdata == '0)); // R9

  AST_OE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_erase |-> &(oe_out | oe_mode)); // R4

  AST_OE_FOLLOWS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_erase |-> (oe_out & oe_mode) == (first_term & oe_mode)); // R5

  AST_FULL_TERMS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (&term_out) |-> (&sum_out)); // R2
endmodule

bind sop_array_core sop_array_chk #(.N_SIG(N_SIG), .N_ROWS(N_ROWS), .GROUP(GROUP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_mode   (oe_mode),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_lock  (cfg_lock),
  .cfg_erase (cfg_erase),
  .cfg_rdata (cfg_rdata),
  .term_out  (term_out),
  .sum_out   (sum_out),
  .oe_out    (oe_out)
);

// File: tb/test_sop_array_core.sv
module test_sop_array_core;
  localparam int NS = 20;
  localparam int NR = 64;
  localparam int NC = 40;
  localparam int NO = 8;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] sig_in;
  logic [NO-1:0] oe_mode;
  logic          cfg_we;
  logic [5:0]    cfg_addr;
  logic [NC-1:0] cfg_wdata;
  logic          cfg_lock;
  logic          cfg_erase;
  logic [NC-1:0] cfg_rdata;
  logic [NR-1:0] term_out;
  logic [NO-1:0] sum_out;
  logic [NO-1:0] oe_out;

  int n_checks;
  int n_fails;
  logic [NC-1:0] mirror [NR];

  localparam logic [NS-1:0] PATS [8] = '{
    20'h00000, 20'hFFFFF, 20'hAAAAA, 20'h55555,
    20'h0F0F0, 20'hF0F0F, 20'h12345, 20'hEDCBA
  };

  sop_array_core i_sop_array_core (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .oe_mode(oe_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .cfg_erase(cfg_erase), .cfg_rdata(cfg_rdata),
    .term_out(term_out), .sum_out(sum_out), .oe_out(oe_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] model_terms(input logic [NS-1:0] s);
    logic [NR-1:0] t;
    for (int r = 0; r < NR; r++) begin
      t[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (mirror[r][c]) t[r] &= (c % 2 == 1) ? ~s[c/2] : s[c/2];
    end
    return t;
  endfunction

  function automatic logic [NO-1:0] model_sums(input logic [NR-1:0] t, input logic [NO-1:0] m);
    logic [NO-1:0] s;
    for (int g = 0; g < NO; g++)
      s[g] = m[g] ? |t[g*8+1 +: 7] : |t[g*8 +: 8];
    return s;
  endfunction

  function automatic logic [NO-1:0] model_oe(input logic [NR-1:0] t, input logic [NO-1:0] m);
    logic [NO-1:0] e;
    for (int g = 0; g < NO; g++) e[g] = m[g] ? t[g*8] : 1'b1;
    return e;
  endfunction

  task automatic write_row(input int a, input logic [NC-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mirror[a] = d;
  endtask

  task automatic load_random_map();
    for (int r = 0; r < NR; r++) begin
      logic [63:0] a, b, c, d;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; d = {$urandom, $urandom};
      write_row(r, (r % 9 == 0) ? '0 : NC'(a & b & c & d));
    end
  endtask

  task automatic sweep(input logic [NO-1:0] m, input string req_sum);
    oe_mode = m;
    for (int p = 0; p < 8; p++) begin
      logic [NR-1:0] et;
      sig_in = PATS[p];
      #1;
      et = model_terms(PATS[p]);
      check("R1 terms", term_out, et);
      check(req_sum, 64'(sum_out), 64'(model_sums(et, m)));
      check(req_sum, 64'(oe_out), 64'(model_oe(et, m)));
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; sig_in = '0; oe_mode = '0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; cfg_lock = 1'b0; cfg_erase = 1'b0;
    for (int r = 0; r < NR; r++) mirror[r] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 terms", term_out, '1);
    check("R10 sums", 64'(sum_out), 64'(8'hFF));
    check("R10 rdata", 64'(cfg_rdata), 64'd0);
    rst_n = 1'b1;

    // Random maps against the model, two enable settings
    for (int k = 0; k < 2; k++) begin
      load_random_map();
      sweep(8'h00, "R4 sum/oe");
      sweep(8'hA5, "R5 sum/oe");
      for (int r = 0; r < NR; r++) begin
        cfg_addr = 6'(r);
        #1;
        check("R7 readback", 64'(cfg_rdata), 64'(mirror[r]));
      end
    end

    // R2 and R3 directed
    oe_mode = '0;
    write_row(6, '0);
    write_row(5, 40'h00000000C0);   // columns 6 and 7: signal 3 both forms
    for (int p = 0; p < 8; p++) begin
      sig_in = PATS[p];
      #1;
      check("R3 clash low", 64'(term_out[5]), 64'd0);
      check("R2 empty high", 64'(term_out[6]), 64'd1);
    end

    // R1 directed: signal 0 true AND signal 1 inverted
    write_row(10, 40'h0000000009);
    sig_in = 20'h00001; #1;
    check("R1 match", 64'(term_out[10]), 64'd1);
    sig_in = 20'h00003; #1;
    check("R1 miss", 64'(term_out[10]), 64'd0);

    // R6: write then readback one cycle later
    write_row(20, 40'hA5A5A5A5A5);
    check("R6 readback", 64'(cfg_rdata), 64'(40'hA5A5A5A5A5));

    // R8: lock hides readback but writes still act
    @(negedge clk); cfg_lock = 1'b1;
    @(negedge clk); cfg_lock = 1'b0;
    cfg_addr = 6'd10; #1;
    check("R8 hidden", 64'(cfg_rdata), 64'd0);
    write_row(10, 40'h0000000002);  // signal 0 inverted only
    sig_in = 20'h00000; #1;
    check("R8 write acts", 64'(term_out[10]), 64'd1);
    sig_in = 20'h00001; #1;
    check("R8 write acts", 64'(term_out[10]), 64'd0);
    check("R8 still hidden", 64'(cfg_rdata), 64'd0);

    // R9: erase with write and lock in the same cycle
    @(negedge clk);
    cfg_erase = 1'b1; cfg_we = 1'b1; cfg_lock = 1'b1;
    cfg_addr = 6'd3; cfg_wdata = 40'hFFFFFFFFFF;
    @(negedge clk);
    cfg_erase = 1'b0; cfg_we = 1'b0; cfg_lock = 1'b0;
    for (int r = 0; r < NR; r++) mirror[r] = '0;
    #1;
    check("R9 terms blank", term_out, '1);
    check("R9 row3 blank", 64'(cfg_rdata), 64'd0);
    write_row(3, 40'h123456789A);
    check("R9 flag cleared", 64'(cfg_rdata), 64'(40'h123456789A));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule